// File: doc/BRIEF.md
# Debug Event Aggregation Register Block

This block is the shared control point for eight bus-comparator units and four counter units in an on-chip debug subsystem. Software reaches it through a small word-addressed register port. Two read-only status words show the live fired and completed flags of all twelve units. Writable words hold the following:

- a per-unit enable
- a per-unit NMI enable
- a two-bit ownership field
- a strobe word that sends single-cycle clear pulses to the counter units

The block also combines the eight comparator event lines into four AND groups and four OR groups. Each group has its own byte of exclusion mask. Any group can be routed to a shared real-time-OS interrupt request. Every writable word is guarded by a write-protect release input.

Top module: `dbg_event_hub`

## Requirements
- R1: After reset the following hold:
  - the enable word, NMI word, owner field and both interrupt-enable words read 0;
  - the AND and OR exclusion masks read 0xFFFFFFFF;
  - every output is low.
- R2: Offset 0x00 reads {counter fired[3:0], comparator fired[7:0]} in bits 11:0. Offset 0x04 reads the completed flags in the same layout. All other bits read 0, and writes to these offsets change nothing.
- R3: The enable word at 0x08 holds bits 11:0, with comparators in 7:0 and counters in 11:8. Upper bits read 0. The `unit_enable` output always equals this word.
- R4: A write to 0x0C drives `cnt_clear` with bits 3:0 of the written data for exactly the following cycle. At all other times `cnt_clear` is 0, and the offset reads 0.
- R5: A write with `wr_unlock` low changes no register and produces no clear pulse.
- R6: The AND mask at 0x18 selects members for each group: byte k (bits 8k+7:8k) serves AND group k, and a 1 excludes that comparator event. `and_out[k]` is 1 only when the group has at least one member and every member's event is high.
- R7: The OR mask at 0x1C uses the same byte layout. `or_out[k]` is 1 when any member of OR group k has its event high. A group with no members drives 0.
- R8: Bits 3:0 of 0x20 enable the AND groups onto `irq_out`, and bits 3:0 of 0x24 enable the OR groups, with 1 meaning enabled. `irq_out` is the OR of all enabled group outputs.
- R9: The NMI word at 0x10 has the same 12-bit layout as the enable word. `nmi_out` is high when a unit's event input is high, its enable bit is set and its NMI bit is set.
- R10: The owner field is bits 1:0 at 0x14 and holds any written value. Its encoding is 00 none, 01 application, 10 debugger, 11 reserved.
- R11: Unmapped word offsets (0x28 and up) read 0 and ignore writes. So does any address whose two low bits are not 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 6 | Byte offset of the register access |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| wr_unlock | input | 1 | Write-protect release; writes take effect only while high |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| cmp_fired | input | 8 | Fired flags of the comparator units |
| cmp_done | input | 8 | Completed flags of the comparator units |
| cnt_fired | input | 4 | Fired flags of the counter units |
| cnt_done | input | 4 | Completed flags of the counter units |
| cmp_event | input | 8 | Comparator event lines |
| cnt_event | input | 4 | Counter event lines |
| unit_enable | output | 12 | Per-unit enable, counters in 11:8 |
| cnt_clear | output | 4 | One-cycle counter clear pulses |
| and_out | output | 4 | AND group outputs |
| or_out | output | 4 | OR group outputs |
| irq_out | output | 1 | Real-time-OS interrupt request |
| nmi_out | output | 1 | Non-maskable interrupt request |

## Verification
The bench targets groups whose members are all excluded. A design that treats an empty AND as true would raise `and_out` and fire the interrupt with no event present.

It also targets the following:
- Writes with the unlock low: a design that ignores the unlock would change the enable word or emit clear pulses.
- Back-to-back clear writes: a design that stretches the pulse or forgets to drop it would show a clear that outlasts its cycle.
- Misaligned and unmapped addresses: a design that decodes only the upper address bits would alias a stray write onto a live register.
- Events on units whose enable bit is clear: a design without the qualification would raise `nmi_out` anyway.

// File: rtl/dbg_event_hub.sv
module dbg_event_hub #(
  parameter int NCMP = 8,
  parameter int NCNT = 4,
  parameter int NGRP = 4,
  parameter int AW   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    reg_addr,
  input  logic             reg_we,
  input  logic [31:0]      reg_wdata,
  input  logic             wr_unlock,
  output logic [31:0]      reg_rdata,
  input  logic [NCMP-1:0]  cmp_fired,
  input  logic [NCMP-1:0]  cmp_done,
  input  logic [NCNT-1:0]  cnt_fired,
  input  logic [NCNT-1:0]  cnt_done,
  input  logic [NCMP-1:0]  cmp_event,
  input  logic [NCNT-1:0]  cnt_event,
  output logic [NCMP+NCNT-1:0] unit_enable,
  output logic [NCNT-1:0]  cnt_clear,
  output logic [NGRP-1:0]  and_out,
  output logic [NGRP-1:0]  or_out,
  output logic             irq_out,
  output logic             nmi_out
);
  localparam int NUNIT = NCMP + NCNT;
  localparam int MW    = NGRP * NCMP;
  localparam int IW    = AW - 2;
  localparam logic [IW-1:0] A_EVT  = IW'(0);
  localparam logic [IW-1:0] A_HALT = IW'(1);
  localparam logic [IW-1:0] A_EN   = IW'(2);
  localparam logic [IW-1:0] A_CLR  = IW'(3);
  localparam logic [IW-1:0] A_NMI  = IW'(4);
  localparam logic [IW-1:0] A_OWN  = IW'(5);
  localparam logic [IW-1:0] A_AMSK = IW'(6);
  localparam logic [IW-1:0] A_OMSK = IW'(7);
  localparam logic [IW-1:0] A_AIM  = IW'(8);
  localparam logic [IW-1:0] A_OIM  = IW'(9);

  logic [IW-1:0]    widx;
  logic             aligned, wr_ok;
  logic [NUNIT-1:0] en_q, nmi_q;
  logic [1:0]       own_q;
  logic [MW-1:0]    amsk_q, omsk_q;
  logic [NGRP-1:0]  aim_q, oim_q;
  logic [NCNT-1:0]  clr_q;

  assign widx    = reg_addr[AW-1:2];
  assign aligned = (reg_addr[1:0] == 2'b00);
  assign wr_ok   = reg_we & wr_unlock & aligned;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      nmi_q  <= '0;
      own_q  <= '0;
      amsk_q <= '1;
      omsk_q <= '1;
      aim_q  <= '0;
      oim_q  <= '0;
      clr_q  <= '0;
    end else begin
      clr_q <= '0;
      if (wr_ok) begin
        case (widx)
          A_EN:    en_q   <= reg_wdata[NUNIT-1:0];
          A_CLR:   clr_q  <= reg_wdata[NCNT-1:0];
          A_NMI:   nmi_q  <= reg_wdata[NUNIT-1:0];
          A_OWN:   own_q  <= reg_wdata[1:0];
          A_AMSK:  amsk_q <= reg_wdata[MW-1:0];
          A_OMSK:  omsk_q <= reg_wdata[MW-1:0];
          A_AIM:   aim_q  <= reg_wdata[NGRP-1:0];
          A_OIM:   oim_q  <= reg_wdata[NGRP-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (aligned) begin
      case (widx)
        A_EVT:   reg_rdata[NUNIT-1:0] = {cnt_fired, cmp_fired};
        A_HALT:  reg_rdata[NUNIT-1:0] = {cnt_done, cmp_done};
        A_EN:    reg_rdata[NUNIT-1:0] = en_q;
        A_NMI:   reg_rdata[NUNIT-1:0] = nmi_q;
        A_OWN:   reg_rdata[1:0]       = own_q;
        A_AMSK:  reg_rdata[MW-1:0]    = amsk_q;
        A_OMSK:  reg_rdata[MW-1:0]    = omsk_q;
        A_AIM:   reg_rdata[NGRP-1:0]  = aim_q;
        A_OIM:   reg_rdata[NGRP-1:0]  = oim_q;
        default: ;
      endcase
    end
  end

  genvar g;
  generate
    for (g = 0; g < NGRP; g++) begin : grp
      logic [NCMP-1:0] inc_a, inc_o;
      assign inc_a      = ~amsk_q[g*NCMP +: NCMP];
      assign inc_o      = ~omsk_q[g*NCMP +: NCMP];
      assign and_out[g] = (|inc_a) & ((cmp_event & inc_a) == inc_a);
      assign or_out[g]  = |(cmp_event & inc_o);

      p_and_has_member_r6: assert property (@(posedge clk) disable iff (!rst_n)
        and_out[g] |-> |(cmp_event & ~amsk_q[g*NCMP +: NCMP]));
      p_or_has_member_r7: assert property (@(posedge clk) disable iff (!rst_n)
        or_out[g] |-> (omsk_q[g*NCMP +: NCMP] != '1));
    end
  endgenerate

  assign unit_enable = en_q;
  assign cnt_clear   = clr_q;
  assign irq_out     = |(and_out & aim_q) | |(or_out & oim_q);
  assign nmi_out     = |({cnt_event, cmp_event} & en_q & nmi_q);

  p_clear_from_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_clear != '0) |-> $past(reg_we && wr_unlock && reg_addr == AW'(12)));
  p_locked_regs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_we && wr_unlock) |-> ($stable(unit_enable) && $stable(amsk_q) && $stable(omsk_q)));
  p_irq_needs_group_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (|and_out || |or_out));
  p_nmi_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_out |-> |(unit_enable & nmi_q));
  p_status_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == AW'(0)) |-> (reg_rdata[31:NUNIT] == '0));
endmodule

// File: tb/dbg_event_hub_test.sv
`timescale 1ns/1ps
module dbg_event_hub_test;
  logic clk = 0, rst_n = 0;
  logic [5:0] reg_addr = 0;
  logic reg_we = 0, wr_unlock = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic [7:0] cmp_fired = 0, cmp_done = 0, cmp_event = 0;
  logic [3:0] cnt_fired = 0, cnt_done = 0, cnt_event = 0;
  logic [11:0] unit_enable;
  logic [3:0] cnt_clear, and_out, or_out;
  logic irq_out, nmi_out;

  int checks = 0, errors = 0;
  bit run_chk = 0;

  // Reference state
  logic [11:0] m_en, m_nmi;
  logic [1:0]  m_own;
  logic [31:0] m_amsk, m_omsk;
  logic [3:0]  m_aim, m_oim, m_clr;

  always #2.5 clk = ~clk;

  dbg_event_hub uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .wr_unlock(wr_unlock), .reg_rdata(reg_rdata),
    .cmp_fired(cmp_fired), .cmp_done(cmp_done), .cnt_fired(cnt_fired),
    .cnt_done(cnt_done), .cmp_event(cmp_event), .cnt_event(cnt_event),
    .unit_enable(unit_enable), .cnt_clear(cnt_clear), .and_out(and_out),
    .or_out(or_out), .irq_out(irq_out), .nmi_out(nmi_out));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_nmi = 0; m_own = 0; m_amsk = '1; m_omsk = '1;
      m_aim = 0; m_oim = 0; m_clr = 0;
    end else begin
      m_clr = 0;
      if (reg_we && wr_unlock && reg_addr[1:0] == 0) begin
        case (int'(reg_addr))
          8:  m_en   = reg_wdata[11:0];
          12: m_clr  = reg_wdata[3:0];
          16: m_nmi  = reg_wdata[11:0];
          20: m_own  = reg_wdata[1:0];
          24: m_amsk = reg_wdata;
          28: m_omsk = reg_wdata;
          32: m_aim  = reg_wdata[3:0];
          36: m_oim  = reg_wdata[3:0];
          default: ;
        endcase
      end
    end
  end

  function automatic logic [3:0] exp_and();
    logic [3:0] r = 0;
    for (int g = 0; g < 4; g++) begin
      int members = 0;
      bit all_hi = 1;
      for (int i = 0; i < 8; i++)
        if (!m_amsk[g*8+i]) begin
          members++;
          if (!cmp_event[i]) all_hi = 0;
        end
      r[g] = (members > 0) && all_hi;
    end
    return r;
  endfunction

  function automatic logic [3:0] exp_or();
    logic [3:0] r = 0;
    for (int g = 0; g < 4; g++)
      for (int i = 0; i < 8; i++)
        if (!m_omsk[g*8+i] && cmp_event[i]) r[g] = 1;
    return r;
  endfunction

  function automatic logic [31:0] exp_rd(logic [5:0] a);
    if (a[1:0] != 0) return 0;
    case (int'(a))
      0:  return {20'd0, cnt_fired, cmp_fired};
      4:  return {20'd0, cnt_done, cmp_done};
      8:  return {20'd0, m_en};
      16: return {20'd0, m_nmi};
      20: return {30'd0, m_own};
      24: return m_amsk;
      28: return m_omsk;
      32: return {28'd0, m_aim};
      36: return {28'd0, m_oim};
      default: return 0;
    endcase
  endfunction

  function automatic string rd_tag(logic [5:0] a);
    if (a[1:0] != 0) return "R11";
    case (int'(a))
      0, 4: return "R2";
      8: return "R3";
      12: return "R4";
      16: return "R9";
      20: return "R10";
      24: return "R6";
      28: return "R7";
      32, 36: return "R8";
      default: return "R11";
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && run_chk) begin
      logic [3:0] ea, eo;
      bit nmi_e;
      ea = exp_and();
      eo = exp_or();
      nmi_e = |({cnt_event, cmp_event} & m_en & m_nmi);
      chk(rd_tag(reg_addr), reg_rdata, exp_rd(reg_addr));
      chk("R3 unit_enable", {20'd0, unit_enable}, {20'd0, m_en});
      chk("R4 cnt_clear", {28'd0, cnt_clear}, {28'd0, m_clr});
      chk("R6 and_out", {28'd0, and_out}, {28'd0, ea});
      chk("R7 or_out", {28'd0, or_out}, {28'd0, eo});
      chk("R8 irq_out", {31'd0, irq_out}, {31'd0, |(ea & m_aim) | |(eo & m_oim)});
      chk("R9 nmi_out", {31'd0, nmi_out}, {31'd0, nmi_e});
    end
  end

  task automatic wr(logic [5:0] a, logic [31:0] d, logic unl);
    @(posedge clk); #1;
    reg_addr = a; reg_wdata = d; wr_unlock = unl; reg_we = 1;
    @(posedge clk); #1;
    reg_we = 0;
  endtask

  task automatic rdchk(logic [5:0] a, logic [31:0] exp, string req);
    @(posedge clk); #1;
    reg_addr = a; reg_we = 0;
    @(negedge clk);
    chk(req, reg_rdata, exp);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 outputs", {unit_enable, cnt_clear, and_out, or_out, irq_out, nmi_out}, 0);
    rdchk(8, 0, "R1 enable");
    rdchk(16, 0, "R1 nmi");
    rdchk(20, 0, "R1 owner");
    rdchk(24, 32'hFFFF_FFFF, "R1 and mask");
    rdchk(28, 32'hFFFF_FFFF, "R1 or mask");
    rdchk(32, 0, "R1 and irq");
    rdchk(36, 0, "R1 or irq");
    run_chk = 1;

    cmp_fired = 8'hA5; cnt_fired = 4'h9; cmp_done = 8'h3C; cnt_done = 4'h6;
    rdchk(0, 32'h9A5, "R2 fired");
    rdchk(4, 32'h63C, "R2 done");
    wr(0, 32'hFFFF_FFFF, 1);
    rdchk(0, 32'h9A5, "R2 write ignored");

    wr(8, 32'hFFF, 0);
    rdchk(8, 0, "R5 locked enable");
    wr(12, 32'hF, 0);
    @(negedge clk); chk("R5 no clear", {28'd0, cnt_clear}, 0);
    wr(8, 32'hFFFF_FFFF, 1);
    rdchk(8, 32'hFFF, "R3 enable width");

    wr(12, 32'h5, 1);
    @(negedge clk); chk("R4 pulse", {28'd0, cnt_clear}, 32'h5);
    @(negedge clk); chk("R4 pulse gone", {28'd0, cnt_clear}, 0);
    rdchk(12, 0, "R4 reads zero");

    wr(20, 32'h3, 1);
    rdchk(20, 3, "R10 owner");
    wr(40, 32'hFFFF_FFFF, 1);
    rdchk(40, 0, "R11 unmapped");
    wr(6'd9, 32'h0, 1);
    rdchk(8, 32'hFFF, "R11 misaligned write ignored");

    wr(24, 32'hFFFF_FFFC, 1);
    wr(32, 32'hF, 1);
    @(posedge clk); #1 cmp_event = 8'h03;
    @(negedge clk); chk("R6 group0 high", {28'd0, and_out}, 32'h1);
    chk("R8 irq from and", {31'd0, irq_out}, 1);
    @(posedge clk); #1 cmp_event = 8'hFF;
    @(negedge clk); chk("R6 empty groups low", {28'd0, and_out}, 32'h1);
    @(posedge clk); #1 cmp_event = 8'h01;
    @(negedge clk); chk("R6 partial low", {28'd0, and_out}, 0);

    wr(8, 32'h0, 1);
    wr(16, 32'hFFF, 1);
    @(posedge clk); #1 cnt_event = 4'hF;
    @(negedge clk); chk("R9 disabled unit no nmi", {31'd0, nmi_out}, 0);
    wr(8, 32'h800, 1);
    @(negedge clk); chk("R9 nmi", {31'd0, nmi_out}, 1);

    for (int n = 0; n < 4000; n++) begin
      @(posedge clk); #1;
      cmp_event = (n % 3 == 0) ? 8'hFF : 8'($urandom);
      cnt_event = 4'($urandom);
      cmp_fired = 8'($urandom); cmp_done = 8'($urandom);
      cnt_fired = 4'($urandom); cnt_done = 4'($urandom);
      reg_we    = ($urandom % 3) == 0;
      wr_unlock = ($urandom % 4) != 0;
      reg_addr  = ($urandom % 8 == 0) ? 6'($urandom) : 6'(4 * ($urandom % 12));
      reg_wdata = $urandom | $urandom;
    end
    @(posedge clk); #1 reg_we = 0;
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule